// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the two-wire serial bus front end of a byte-addressed 64-kbit memory slave. It takes SCL and SDA that have already been synchronized and glitch-filtered into the system clock domain. It finds START and STOP conditions and assembles 8-bit words, most significant bit first. It answers a device select byte whose top four bits are the fixed prefix 1010 and whose next three bits must equal three strap inputs. It acknowledges each byte it accepts by pulling SDA low during the ninth clock.

Writes carry two address bytes that form a 13-bit word pointer, followed by one or more data bytes. Each data byte leaves the block as a one-cycle write strobe that carries its address and value for an external write-cycle controller. A STOP that closes a write with at least one accepted data byte raises a commit request. While that controller reports a write in progress, the block refuses every select byte. Reads take bytes from an external memory read port at the internal pointer. The pointer moves on after every byte, so current-address, random (dummy write, repeated START, read select) and sequential reads all work. SDA is only ever pulled low, through an active-high pull-down enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) is never taken as a data bit. Either one drops any partial byte and releases SDA. After a START the next eight bits are taken as a select byte.
- R2: A select byte of 1010, then bits equal to strap[2:0], then R/W (bit 0) is acknowledged: sdaPull is high for the whole high phase of the ninth SCL pulse.
- R3: A select byte whose prefix or strap bits do not match is not acknowledged, and no later byte is acknowledged until the next START.
- R4: While wrBusy is high, a select byte that would otherwise match is not acknowledged.
- R5: In a write (R/W = 0) the two bytes after the select byte form the 13-bit pointer {first[4:0], second}; the upper three bits of the first byte are ignored. Each later data byte is acknowledged and gives exactly one one-cycle wrValid pulse with wrAddr equal to the pointer and wrData equal to the byte.
- R6: After each write data byte, only the low 5 bits of the pointer increment, so a write wraps to the start of its 32-byte page.
- R7: commitReq pulses for one cycle on a STOP that ends a write with at least one acknowledged data byte, including a STOP in the middle of a later byte. A write closed by STOP or by a repeated START before any data byte gives no commit.
- R8: The pointer is zero after reset. A read (R/W = 1) returns the byte at the pointer, which is the last address accessed plus one (within the page after a write).
- R9: A write select byte and two address bytes, then a repeated START and a read select byte, return the byte at the loaded address.
- R10: A master acknowledge (SDA low on the ninth clock of a read byte) makes the slave send the byte at the next address. The full 13-bit pointer wraps from 0x1FFF to 0x0000.
- R11: After a master NACK the slave releases SDA and does not pull it low again until the next START.
- R12: sdaPull only rises while SCL is low: output data and acknowledges change after SCL falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronized, filtered serial clock |
| sda | input | 1 | Synchronized, filtered serial data (wired bus value) |
| strap | input | 3 | Device address straps compared with select bits 3..1 |
| wrBusy | input | 1 | Write-cycle controller is programming the array |
| rdData | input | 8 | Memory byte at rdAddr |
| rdAddr | output | 13 | Memory read address (current pointer) |
| sdaPull | output | 1 | Pull-down enable for the SDA pad |
| wrValid | output | 1 | One-cycle strobe for an accepted write data byte |
| wrAddr | output | 13 | Address of the write data byte |
| wrData | output | 8 | Write data byte |
| commitReq | output | 1 | One-cycle request to program the staged bytes |

## Verification
The hardest case to reach is a control condition arriving in the middle of a frame. One example is a STOP after some data bits of a second write byte, where the first byte was already acknowledged and the commit must still fire. Another is a START four bits into a select byte, which must throw away the partial word. The bench reaches these by clocking a chosen number of bits by hand and then issuing the START or STOP with SCL high. The pointer wrap from 0x1FFF to 0x0000 is reached with a random read loaded near the top of the address space, followed by master acknowledges.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
  localparam int ADDR_W   = 13;
  localparam int PAGE_W   = 5;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int PREFIX_W = 4;

  // events seen on the bus, produced by the datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic byteEnd;    // falling edge of the 8th clock of a frame
    logic frameEnd;   // falling edge of the 9th clock of a frame
    logic masterAck;  // SDA was low on the 9th rising edge
  } evt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ackByte;
    logic txMode;
    logic loadRd;
    logic ldHi;
    logic ldLo;
    logic wrByte;
  } strb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } st_t;
endpackage

// File: rtl/eeslv_datapath.sv
module eeslv_datapath
  import eeslv_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int PAGE_BITS = PAGE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scl,
  input  logic                 sda,
  input  strb_t                strb,
  input  logic [BYTE_W-1:0]    rdData,
  output evt_t                 evt,
  output logic [BYTE_W-1:0]    rxByte,
  output logic [ADDR_BITS-1:0] rdAddr,
  output logic                 sdaPull,
  output logic                 wrValid,
  output logic [ADDR_BITS-1:0] wrAddr,
  output logic [BYTE_W-1:0]    wrData
);
  localparam int HI_W = ADDR_BITS - BYTE_W;

  logic                 sclQ, sdaQ;
  logic [3:0]           bitCnt;
  logic [BYTE_W-1:0]    rxShift;
  logic [BYTE_W-1:0]    txShift;
  logic [ADDR_BITS-1:0] ptr;
  logic [HI_W-1:0]      hiStage;
  logic                 mAck;
  logic                 sclRise, sclFall, startC, stopC;

  // bus condition decode
  always_comb begin
    sclRise = scl & ~sclQ;
    sclFall = ~scl & sclQ;
    startC  = scl & sclQ & sdaQ & ~sda;
    stopC   = scl & sclQ & ~sdaQ & sda;
    evt.start     = startC;
    evt.stop      = stopC;
    evt.byteEnd   = sclFall && (bitCnt == 4'd8);
    evt.frameEnd  = sclFall && (bitCnt == 4'd9);
    evt.masterAck = mAck;
  end

  assign rxByte = rxShift;
  assign rdAddr = ptr;

  // bit framing, shifters and the SDA pull-down
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      sdaPull <= 1'b0;
      mAck    <= 1'b0;
    end else begin
      sclQ <= scl;
      sdaQ <= sda;
      if (startC || stopC) begin
        bitCnt  <= '0;
        sdaPull <= 1'b0;
      end else begin
        if (sclRise && bitCnt < 4'd9) begin
          bitCnt <= bitCnt + 4'd1;
          if (bitCnt < 4'd8) rxShift <= {rxShift[BYTE_W-2:0], sda};
          if (bitCnt == 4'd8) mAck <= ~sda;
        end
        if (sclFall) begin
          if (bitCnt == 4'd8) begin
            sdaPull <= strb.ackByte;
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            if (strb.loadRd) begin
              txShift <= rdData;
              sdaPull <= ~rdData[BYTE_W-1];
            end else begin
              sdaPull <= 1'b0;
            end
          end else if (strb.txMode && bitCnt != 4'd0) begin
            txShift <= {txShift[BYTE_W-2:0], 1'b0};
            sdaPull <= ~txShift[BYTE_W-2];
          end
        end
      end
    end
  end

  // word pointer and write strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      hiStage <= '0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= 1'b0;
      if (strb.ldHi) hiStage <= rxShift[HI_W-1:0];
      if (strb.ldLo) ptr <= {hiStage, rxShift};
      if (strb.wrByte) begin
        wrValid <= 1'b1;
        wrAddr  <= ptr;
        wrData  <= rxShift;
        ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
      end
      if (strb.loadRd) ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/eeslv_control.sv
module eeslv_control
  import eeslv_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  evt_t               evt,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wrBusy,
  output strb_t              strb,
  output logic               commitReq
);
  st_t  state;
  logic wrote;
  logic firstRd;
  logic selMatch;

  assign selMatch = (rxByte[BYTE_W-1 -: PREFIX_W] == DEV_PREFIX) &&
                    (rxByte[STRAP_W:1] == strap) && !wrBusy;

  always_comb begin
    strb        = '0;
    strb.txMode = (state == ST_RDAT);
    if (evt.byteEnd) begin
      unique case (state)
        ST_DEV:  strb.ackByte = selMatch;
        ST_AHI:  begin strb.ackByte = 1'b1; strb.ldHi = 1'b1; end
        ST_ALO:  begin strb.ackByte = 1'b1; strb.ldLo = 1'b1; end
        ST_WDAT: begin strb.ackByte = 1'b1; strb.wrByte = 1'b1; end
        default: ;
      endcase
    end
    if (evt.frameEnd && state == ST_RDAT && (firstRd || evt.masterAck))
      strb.loadRd = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wrote     <= 1'b0;
      firstRd   <= 1'b0;
      commitReq <= 1'b0;
    end else begin
      commitReq <= 1'b0;
      if (evt.start) begin
        state   <= ST_DEV;
        wrote   <= 1'b0;
        firstRd <= 1'b0;
      end else if (evt.stop) begin
        if (state == ST_WDAT && wrote) commitReq <= 1'b1;
        state <= ST_IDLE;
        wrote <= 1'b0;
      end else if (evt.byteEnd) begin
        unique case (state)
          ST_DEV: begin
            if (!selMatch)      state <= ST_IDLE;
            else if (rxByte[0]) begin state <= ST_RDAT; firstRd <= 1'b1; end
            else                state <= ST_AHI;
          end
          ST_AHI:  state <= ST_ALO;
          ST_ALO:  state <= ST_WDAT;
          ST_WDAT: wrote <= 1'b1;
          default: ;
        endcase
      end else if (evt.frameEnd && state == ST_RDAT) begin
        firstRd <= 1'b0;
        if (!(firstRd || evt.masterAck)) state <= ST_WAIT;
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeslv_pkg::*;
#(
  parameter int                  ADDR_BITS  = ADDR_W,
  parameter int                  PAGE_BITS  = PAGE_W,
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scl,
  input  logic                 sda,
  input  logic [STRAP_W-1:0]   strap,
  input  logic                 wrBusy,
  input  logic [BYTE_W-1:0]    rdData,
  output logic [ADDR_BITS-1:0] rdAddr,
  output logic                 sdaPull,
  output logic                 wrValid,
  output logic [ADDR_BITS-1:0] wrAddr,
  output logic [BYTE_W-1:0]    wrData,
  output logic                 commitReq
);
  evt_t              evt;
  strb_t             strb;
  logic [BYTE_W-1:0] rxByte;

  eeslv_datapath #(.ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda), .strb(strb),
    .rdData(rdData), .evt(evt), .rxByte(rxByte), .rdAddr(rdAddr),
    .sdaPull(sdaPull), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  eeslv_control #(.DEV_PREFIX(DEV_PREFIX)) u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .strap(strap),
    .wrBusy(wrBusy), .strb(strb), .commitReq(commitReq)
  );
endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker (
  input logic clk,
  input logic rstN,
  input logic scl,
  input logic sda,
  input logic sdaPull,
  input logic wrValid,
  input logic commitReq
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPull) |-> !scl); // R12
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl) && sda && !$past(sda)) |=> !sdaPull); // R1
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid); // R5
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |=> !commitReq); // R7
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> ($past(scl) && $past(sda))); // R7
endmodule

bind i2c_eeprom_slave eeslv_checker u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .sda(sda),
  .sdaPull(sdaPull), .wrValid(wrValid), .commitReq(commitReq)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int H = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic busSda;
  logic [7:0] rdData;
  logic [12:0] rdAddr, wrAddr;
  logic [7:0] wrData;
  logic sdaPull, wrValid, commitReq, wrBusy;
  int busyCnt = 0;
  int commits = 0;
  int pullRiseHigh = 0;
  int vectors = 0;
  int miscompares = 0;
  logic pullQ = 1'b0;
  logic [7:0] mem [int];
  logic [7:0] stage [int];
  int wrLogA[$];
  int wrLogD[$];

  always #5 clk = ~clk;
  assign busSda = sdaM & ~sdaPull;
  assign wrBusy = (busyCnt != 0);

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(busSda), .strap(STRAP),
    .wrBusy(wrBusy), .rdData(rdData), .rdAddr(rdAddr), .sdaPull(sdaPull),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .commitReq(commitReq)
  );

  function automatic logic [7:0] defByte(int a);
    return 8'(a) ^ 8'((a >> 8) << 3);
  endfunction

  function automatic logic [7:0] memRead(int a);
    if (mem.exists(a)) return mem[a];
    return defByte(a);
  endfunction

  // write-cycle controller and memory model
  always @(negedge clk) begin
    rdData <= memRead(int'(rdAddr));
    if (busyCnt > 0) busyCnt <= busyCnt - 1;
    if (wrValid) begin
      wrLogA.push_back(int'(wrAddr));
      wrLogD.push_back(int'(wrData));
      stage[int'(wrAddr)] = wrData;
    end
    if (commitReq) begin
      commits <= commits + 1;
      foreach (stage[k]) mem[k] = stage[k];
      stage.delete();
      busyCnt <= 400;
    end
    if (rstN && sdaPull && !pullQ && scl) pullRiseHigh <= pullRiseHigh + 1;
    pullQ <= sdaPull;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic i2cStart();
    stage.delete();
    sdaM = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(2);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output bit acked);
    bit pullAll = 1'b1;
    sendBits(b, 8);
    sdaM = 1'b1; tick(H);
    scl = 1'b1;
    for (int i = 0; i < H; i++) begin
      tick(1);
      if (!sdaPull) pullAll = 1'b0;
    end
    acked = pullAll;
    scl = 1'b0; tick(2);
  endtask

  task automatic recvByte(bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H / 2);
      b[i] = busSda; tick(H / 2);
      scl = 1'b0;
    end
    tick(1);
    sdaM = giveAck ? 1'b0 : 1'b1; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(1);
    sdaM = 1'b1; tick(1);
  endtask

  task automatic waitIdle();
    tick(4);
    while (wrBusy) tick(1);
  endtask

  task automatic clearLog();
    wrLogA.delete();
    wrLogD.delete();
  endtask

  task automatic sendExpect(logic [7:0] b, bit expAck, string req);
    bit a;
    sendByte(b, a);
    chk(a == expAck, req, $sformatf("ack for byte %0h", b), int'(a), int'(expAck));
  endtask

  task automatic readExpect(bit giveAck, int expAddr, string req);
    logic [7:0] d;
    recvByte(giveAck, d);
    chk(d == memRead(expAddr), req, $sformatf("read data at %0h", expAddr),
        int'(d), int'(memRead(expAddr)));
  endtask

  task automatic testReset();
    chk(sdaPull == 1'b0, "R12", "sdaPull after reset", int'(sdaPull), 0);
    chk(rdAddr == 13'h0, "R8", "pointer after reset", int'(rdAddr), 0);
    chk(!wrValid && !commitReq, "R7", "strobes after reset", int'({wrValid, commitReq}), 0);
    i2cStart(); sendExpect(SEL_R, 1'b1, "R2");
    readExpect(1'b0, 'h0000, "R8"); i2cStop();
  endtask

  task automatic testMismatch();
    clearLog();
    i2cStart(); sendExpect(8'hA2, 1'b0, "R3");
    sendExpect(SEL_W, 1'b0, "R3"); i2cStop();
    i2cStart(); sendExpect(8'hBA, 1'b0, "R3"); i2cStop();
    chk(wrLogA.size() == 0, "R3", "write strobes after mismatch", wrLogA.size(), 0);
  endtask

  task automatic testByteWrite();
    int c0 = commits;
    clearLog();
    i2cStart(); sendExpect(SEL_W, 1'b1, "R2");
    sendExpect(8'hE1, 1'b1, "R5"); sendExpect(8'h23, 1'b1, "R5");
    sendExpect(8'h5C, 1'b1, "R5"); i2cStop(); tick(4);
    chk(wrLogA.size() == 1, "R5", "strobe count", wrLogA.size(), 1);
    if (wrLogA.size() == 1) begin
      chk(wrLogA[0] == 'h0123, "R5", "wrAddr", wrLogA[0], 'h0123);
      chk(wrLogD[0] == 'h5C, "R5", "wrData", wrLogD[0], 'h5C);
    end
    chk(commits == c0 + 1, "R7", "commit after byte write", commits, c0 + 1);
  endtask

  task automatic testBusy();
    int c0 = commits;
    i2cStart(); sendExpect(SEL_W, 1'b0, "R4"); i2cStop();
    waitIdle();
    i2cStart(); sendExpect(SEL_W, 1'b1, "R4"); i2cStop(); tick(4);
    chk(commits == c0, "R7", "no commit without data", commits, c0);
  endtask

  task automatic testPageWrap();
    int exp[4] = '{'h1FE, 'h1FF, 'h1E0, 'h1E1};
    clearLog();
    i2cStart(); sendExpect(SEL_W, 1'b1, "R6");
    sendExpect(8'h01, 1'b1, "R6"); sendExpect(8'hFE, 1'b1, "R6");
    sendExpect(8'h11, 1'b1, "R6"); sendExpect(8'h22, 1'b1, "R6");
    sendExpect(8'h33, 1'b1, "R6"); sendExpect(8'h44, 1'b1, "R6");
    i2cStop(); tick(4);
    chk(wrLogA.size() == 4, "R6", "strobe count", wrLogA.size(), 4);
    for (int i = 0; i < 4 && i < wrLogA.size(); i++)
      chk(wrLogA[i] == exp[i], "R6", "page wrap address", wrLogA[i], exp[i]);
    waitIdle();
  endtask

  task automatic testRandomRead();
    int c0 = commits;
    i2cStart(); sendExpect(SEL_W, 1'b1, "R9");
    sendExpect(8'h01, 1'b1, "R9"); sendExpect(8'hFF, 1'b1, "R9");
    i2cStart(); sendExpect(SEL_R, 1'b1, "R9");
    readExpect(1'b0, 'h01FF, "R9"); i2cStop(); tick(4);
    chk(commits == c0, "R7", "no commit after dummy write", commits, c0);
  endtask

  task automatic testSeqRead();
    i2cStart(); sendExpect(SEL_W, 1'b1, "R10");
    sendExpect(8'h1F, 1'b1, "R10"); sendExpect(8'hFE, 1'b1, "R10");
    i2cStart(); sendExpect(SEL_R, 1'b1, "R10");
    readExpect(1'b1, 'h1FFE, "R10"); readExpect(1'b1, 'h1FFF, "R10");
    readExpect(1'b0, 'h0000, "R10"); i2cStop();
    i2cStart(); sendExpect(SEL_R, 1'b1, "R10");
    readExpect(1'b0, 'h0001, "R10"); i2cStop();
  endtask

  task automatic testNackRelease();
    int pulled = 0;
    i2cStart(); sendExpect(SEL_R, 1'b1, "R11");
    readExpect(1'b0, 'h0002, "R11");
    sdaM = 1'b1;
    for (int i = 0; i < 9; i++) begin
      scl = 1'b1;
      for (int j = 0; j < H; j++) begin tick(1); if (sdaPull) pulled++; end
      scl = 1'b0;
      for (int j = 0; j < H; j++) begin tick(1); if (sdaPull) pulled++; end
    end
    chk(pulled == 0, "R11", "pull cycles after master NACK", pulled, 0);
    i2cStop();
  endtask

  task automatic testAbort();
    int c0;
    i2cStart(); sendBits(SEL_W, 4);
    i2cStart(); sendExpect(SEL_R, 1'b1, "R1");
    readExpect(1'b0, 'h0003, "R1"); i2cStop();
    c0 = commits; clearLog();
    i2cStart(); sendExpect(SEL_W, 1'b1, "R7");
    sendExpect(8'h00, 1'b1, "R7"); sendExpect(8'h40, 1'b1, "R7");
    sendExpect(8'h77, 1'b1, "R7"); sendBits(8'hE0, 3);
    scl = 1'b0; i2cStop(); tick(4);
    chk(commits == c0 + 1, "R7", "commit on stop mid byte", commits, c0 + 1);
    chk(wrLogA.size() == 1, "R1", "partial byte discarded", wrLogA.size(), 1);
    waitIdle(); c0 = commits;
    i2cStart(); sendExpect(SEL_W, 1'b1, "R7");
    sendExpect(8'h00, 1'b1, "R7"); sendExpect(8'h50, 1'b1, "R7");
    i2cStop(); tick(4);
    chk(commits == c0, "R7", "no commit after address only", commits, c0);
    i2cStart(); sendExpect(SEL_R, 1'b1, "R8");
    readExpect(1'b0, 'h0050, "R8"); i2cStop();
  endtask

  task automatic finishRun();
    chk(pullRiseHigh == 0, "R12", "pull rises with SCL high", pullRiseHigh, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testMismatch();
    testByteWrite();
    testBusy();
    i2cStart(); sendExpect(SEL_R, 1'b1, "R8");
    readExpect(1'b0, 'h0124, "R8"); i2cStop();
    testPageWrap();
    testRandomRead();
    testSeqRead();
    testNackRelease();
    testAbort();
    finishRun();
  end
endmodule